// File: doc/BRIEF.md
# UART Receive Character Queue with Overrun Guard

This block sits behind a UART receive shifter and queues finished characters until they are read. Each character is nine data bits plus a parity-error flag and a framing-error flag. A four-entry circular buffer is backed by one holding stage that can keep a fifth complete character while the buffer is full. The oldest stored character is always shown on the head outputs, and a data-available flag reports whether the buffer holds anything.

Every move of a character into the buffer is a transfer. A two-bit threshold select decides which transfers raise a one-cycle interrupt pulse: every transfer, or only the one that brings the buffer to three words, or only the one that fills it. When the buffer and the holding stage are both occupied and another character arrives, a sticky overrun flag is raised and intake stops. Characters already held stay readable. Intake resumes only after an explicit clear or a reset.

Top module: `uart_rx_queue`

## Requirements
- R1: The buffer stores 4 characters and the holding stage keeps a fifth while the buffer is full, so five characters arriving back to back are all delivered later in arrival order.
- R2: `rxq_avail` is 1 whenever the buffer holds at least one character and 0 when it is empty.
- R3: A read strobe while the buffer is empty moves nothing, and the head outputs keep showing the last character that was read.
- R4: A read of a non-empty buffer removes the head, and on the next cycle the head data and both error flags show the following character. The head word is ordered {data, parity error, framing error}.
- R5: With threshold select 2'b00 or 2'b01, `rxq_irq` pulses for one cycle after every transfer into the buffer.
- R6: With threshold select 2'b10, the pulse follows only a transfer that leaves exactly 3 words in the buffer. With 2'b11, it follows only a transfer that leaves 4 words (full).
- R7: Overrun is set in the cycle after a character strobe arrives while the buffer is full and the holding stage is occupied. That character is dropped.
- R8: While overrun is set, arriving characters are ignored, and the stored characters, including the one in the holding stage, remain deliverable in order.
- R9: Overrun stays set until `ovr_clr` or reset. The clear does not remove stored characters.
- R10: When a read frees a slot while the holding stage is occupied, the held character moves into the buffer in the following cycle, and this move counts as a transfer for the interrupt.
- R11: A read and a transfer in the same cycle leave the word count unchanged and keep the arrival order.
- R12: Reset empties the queue, clears overrun and the interrupt, and sets the head outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_vld | input | 1 | A completed character is presented this cycle |
| chr_data | input | 9 | Data bits of the arriving character |
| chr_perr | input | 1 | Parity error of the arriving character |
| chr_ferr | input | 1 | Framing error of the arriving character |
| rd_stb | input | 1 | Consume the head character |
| thr_sel | input | 2 | Interrupt threshold select |
| ovr_clr | input | 1 | Clear the overrun flag |
| head_data | output | 9 | Data bits of the head character |
| head_perr | output | 1 | Parity error of the head character |
| head_ferr | output | 1 | Framing error of the head character |
| rxq_avail | output | 1 | Buffer is not empty |
| rxq_irq | output | 1 | One-cycle threshold interrupt |
| rxq_ovr | output | 1 | Sticky overrun flag |

## Verification
A read and a transfer can fall in the same cycle in two ways. A new character can arrive directly while the head is read. A read can also release the held character, which then moves in while the next read is already under way. The vector table provokes both. It reads the full buffer while a new character arrives, which parks that character in the holding stage, and then reads again as the parked character moves in. It also reads a one-word buffer while a fresh character arrives. Each case is judged on the head value, the available flag and the interrupt, and on the order in which the later reads return the characters.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    THR_EACH_A   = 2'b00,
    THR_EACH_B   = 2'b01,
    THR_NEARFULL = 2'b10,
    THR_FULL     = 2'b11
  } thr_e;

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned wrap_dec(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_vld,
  input  logic [CW-1:0] chr_word,
  input  logic          slot_free,
  input  logic          ovr_clr,
  output logic          push,
  output logic [CW-1:0] push_word,
  output logic          ovr
);

  logic          hold_vld_q, hold_vld_n;
  logic [CW-1:0] hold_q;
  logic          hold_ld;
  logic          ovr_q, ovr_n;
  logic          chr_acc;
  logic          ovr_set;

  // next-state logic
  always_comb begin
    chr_acc    = chr_vld && !ovr_q;
    push       = slot_free && (hold_vld_q || chr_acc);
    push_word  = hold_vld_q ? hold_q : chr_word;
    hold_vld_n = hold_vld_q;
    hold_ld    = 1'b0;
    ovr_set    = 1'b0;
    if (hold_vld_q) begin
      if (slot_free) begin
        hold_vld_n = chr_acc;
        hold_ld    = chr_acc;
      end else if (chr_acc) begin
        ovr_set = 1'b1;
      end
    end else if (chr_acc && !slot_free) begin
      hold_vld_n = 1'b1;
      hold_ld    = 1'b1;
    end
    if (ovr_set) begin
      ovr_n = 1'b1;
    end else if (ovr_clr) begin
      ovr_n = 1'b0;
    end else begin
      ovr_n = ovr_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      hold_vld_q <= hold_vld_n;
      ovr_q      <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_ld) begin
      hold_q <= chr_word;
    end
  end

  assign ovr = ovr_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 4,
  parameter int CW    = 11,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [CW-1:0]   push_word,
  input  logic            rd_req,
  output logic [CW-1:0]   head_word,
  output logic [CNTW-1:0] cnt,
  output logic [CNTW-1:0] cnt_after,
  output logic            slot_free,
  output logic            avail
);

  logic [CW-1:0]   mem [DEPTH];
  logic [PW-1:0]   rd_ptr_q, rd_ptr_n;
  logic [PW-1:0]   wr_ptr_q, wr_ptr_n;
  logic [PW-1:0]   prev_ptr;
  logic [CNTW-1:0] cnt_q;
  logic            pop;

  // next-state logic
  always_comb begin
    pop       = rd_req && (cnt_q != '0);
    slot_free = (cnt_q != CNTW'(DEPTH));
    rd_ptr_n  = pop  ? PW'(rxq_pkg::wrap_inc(int'(rd_ptr_q), DEPTH)) : rd_ptr_q;
    wr_ptr_n  = push ? PW'(rxq_pkg::wrap_inc(int'(wr_ptr_q), DEPTH)) : wr_ptr_q;
    prev_ptr  = PW'(rxq_pkg::wrap_dec(int'(rd_ptr_q), DEPTH));
    case ({push, pop})
      2'b10:   cnt_after = cnt_q + CNTW'(1);
      2'b01:   cnt_after = cnt_q - CNTW'(1);
      default: cnt_after = cnt_q;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_n;
      wr_ptr_q <= wr_ptr_n;
      cnt_q    <= cnt_after;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (push && (wr_ptr_q == PW'(i))) begin
        mem[i] <= push_word;
      end
    end
  end

  assign avail     = (cnt_q != '0);
  assign head_word = avail ? mem[rd_ptr_q] : mem[prev_ptr];
  assign cnt       = cnt_q;

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int DEPTH = 4,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [CNTW-1:0] cnt_after,
  input  logic [1:0]      thr_sel,
  output logic            irq
);

  logic irq_q, irq_n;
  rxq_pkg::thr_e mode;

  always_comb begin
    mode = rxq_pkg::thr_e'(thr_sel);
    case (mode)
      rxq_pkg::THR_NEARFULL: irq_n = push && (cnt_after == CNTW'(DEPTH - 1));
      rxq_pkg::THR_FULL:     irq_n = push && (cnt_after == CNTW'(DEPTH));
      default:               irq_n = push;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chr_vld,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_perr,
  input  logic              chr_ferr,
  input  logic              rd_stb,
  input  logic [1:0]        thr_sel,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] head_data,
  output logic              head_perr,
  output logic              head_ferr,
  output logic              rxq_avail,
  output logic              rxq_irq,
  output logic              rxq_ovr
);

  localparam int CW   = DATA_W + 2;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            srst_n;
  logic [CW-1:0]   chr_word;
  logic            push;
  logic [CW-1:0]   push_word;
  logic            slot_free;
  logic [CW-1:0]   head_word;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_after;

  assign chr_word = {chr_data, chr_perr, chr_ferr};

  rxq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rxq_hold #(.CW(CW)) u_hold (
    .clk       (clk),
    .rst_n     (srst_n),
    .chr_vld   (chr_vld),
    .chr_word  (chr_word),
    .slot_free (slot_free),
    .ovr_clr   (ovr_clr),
    .push      (push),
    .push_word (push_word),
    .ovr       (rxq_ovr)
  );

  rxq_store #(.DEPTH(DEPTH), .CW(CW), .PW(PW), .CNTW(CNTW)) u_store (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (push),
    .push_word (push_word),
    .rd_req    (rd_stb),
    .head_word (head_word),
    .cnt       (cnt_q),
    .cnt_after (cnt_after),
    .slot_free (slot_free),
    .avail     (rxq_avail)
  );

  rxq_irq #(.DEPTH(DEPTH), .CNTW(CNTW)) u_irq (
    .clk       (clk),
    .rst_n     (srst_n),
    .push      (push),
    .cnt_after (cnt_after),
    .thr_sel   (thr_sel),
    .irq       (rxq_irq)
  );

  assign head_data = head_word[CW-1:2];
  assign head_perr = head_word[1];
  assign head_ferr = head_word[0];

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  parameter int CNTW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chr_vld,
  input logic              rd_stb,
  input logic              ovr_clr,
  input logic [1:0]        thr_sel,
  input logic [DATA_W-1:0] head_data,
  input logic              rxq_avail,
  input logic              rxq_irq,
  input logic              rxq_ovr,
  input logic [CNTW-1:0]   cnt
);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));

  // R3
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxq_avail && rd_stb && !chr_vld) |=> $stable(head_data));

  // R5
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_irq |-> rxq_avail);

  // R6
  irq_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel == 2'b11) |=> (!rxq_irq || (cnt == CNTW'(DEPTH))));

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxq_ovr) |-> $past(chr_vld));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_ovr && !ovr_clr) |=> rxq_ovr);

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxq_ovr && ovr_clr) |=> !rxq_ovr);

endmodule

bind uart_rx_queue rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chr_vld   (chr_vld),
  .rd_stb    (rd_stb),
  .ovr_clr   (ovr_clr),
  .thr_sel   (thr_sel),
  .head_data (head_data),
  .rxq_avail (rxq_avail),
  .rxq_irq   (rxq_irq),
  .rxq_ovr   (rxq_ovr),
  .cnt       (cnt_q)
);

// File: tb/uart_rx_queue_bench.sv
`timescale 1ns/1ps
module uart_rx_queue_bench;

  logic       clk;
  logic       rst_n;
  logic       chr_vld;
  logic [8:0] chr_data;
  logic       chr_perr;
  logic       chr_ferr;
  logic       rd_stb;
  logic [1:0] thr_sel;
  logic       ovr_clr;
  logic [8:0] head_data;
  logic       head_perr;
  logic       head_ferr;
  logic       rxq_avail;
  logic       rxq_irq;
  logic       rxq_ovr;

  int n_chk;
  int n_bad;
  bit done;

  uart_rx_queue u_uart_rx_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .chr_vld   (chr_vld),
    .chr_data  (chr_data),
    .chr_perr  (chr_perr),
    .chr_ferr  (chr_ferr),
    .rd_stb    (rd_stb),
    .thr_sel   (thr_sel),
    .ovr_clr   (ovr_clr),
    .head_data (head_data),
    .head_perr (head_perr),
    .head_ferr (head_ferr),
    .rxq_avail (rxq_avail),
    .rxq_irq   (rxq_irq),
    .rxq_ovr   (rxq_ovr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector layout: {vld, data[8:0], perr, ferr, rd, thr[1:0], clr,
  //                 exp_avail, exp_irq, exp_ovr, exp_data[8:0], exp_perr, exp_ferr}
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 9'h101, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0,  1'b1, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h0AA, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0,  1'b1, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0,  1'b1, 1'b0, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h055, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0,  1'b1, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h1FF, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0,  1'b1, 1'b0, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h033, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0,  1'b1, 1'b0, 1'b0, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h044, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0,  1'b1, 1'b0, 1'b1, 9'h101, 1'b0, 1'b0},
    {1'b1, 9'h077, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0,  1'b1, 1'b0, 1'b1, 9'h101, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0,  1'b1, 1'b0, 1'b1, 9'h0AA, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0,  1'b1, 1'b1, 1'b1, 9'h0AA, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1,  1'b1, 1'b0, 1'b0, 9'h0AA, 1'b1, 1'b0},
    {1'b1, 9'h0F0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b1, 1'b0, 1'b0, 9'h055, 1'b0, 1'b1},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b1, 1'b1, 1'b0, 9'h1FF, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b1, 1'b0, 1'b0, 9'h033, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b1, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b0, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0,  1'b0, 1'b0, 1'b0, 9'h0F0, 1'b0, 1'b0},
    {1'b1, 9'h012, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0,  1'b1, 1'b1, 1'b0, 9'h012, 1'b0, 1'b0},
    {1'b1, 9'h0C3, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0,  1'b1, 1'b1, 1'b0, 9'h0C3, 1'b1, 1'b1},
    {1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0,  1'b0, 1'b0, 1'b0, 9'h0C3, 1'b1, 1'b1}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1:   return "R5";
      2:      return "R2";
      3, 4:   return "R6";
      5:      return "R1";
      6:      return "R7";
      7:      return "R8";
      8:      return "R4";
      9:      return "R10";
      10:     return "R9";
      11:     return "R1";
      12:     return "R11";
      13, 14: return "R8";
      15:     return "R2";
      16:     return "R3";
      17:     return "R5";
      18:     return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [13:0] exp);
    logic [13:0] act;
    act = {rxq_avail, rxq_irq, rxq_ovr, head_data, head_perr, head_ferr};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got avail/irq/ovr/head=%b/%b/%b/%h.%b%b expected %b/%b/%b/%h.%b%b",
               tag, act[13], act[12], act[11], act[10:2], act[1], act[0],
               exp[13], exp[12], exp[11], exp[10:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic v, input logic [8:0] d, input logic pe, input logic fe,
                       input logic rd, input logic [1:0] thr, input logic clr);
    @(negedge clk);
    chr_vld  = v;
    chr_data = d;
    chr_perr = pe;
    chr_ferr = fe;
    rd_stb   = rd;
    thr_sel  = thr;
    ovr_clr  = clr;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    chr_vld = 1'b0; chr_data = '0; chr_perr = 1'b0; chr_ferr = 1'b0;
    rd_stb = 1'b0; thr_sel = 2'b00; ovr_clr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R12: reset state
    compare("R12", 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    compare("R12", 14'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29], VEC[i][28:20], VEC[i][19], VEC[i][18],
            VEC[i][17], VEC[i][16:15], VEC[i][14]);
      compare(req_of(i), VEC[i][13:0]);
    end

    // R9: clear while no overrun leaves the queue empty and flags low
    drive(1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    compare("R9", {3'b000, 9'h0C3, 2'b11});

    // R7: six back-to-back characters overflow the five storage places
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 9'(9'h010 + k), 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    end
    drive(1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    compare("R7", {3'b101, 9'h010, 2'b00});

    // R12: reset mid-operation empties everything and clears overrun
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    compare("R12", 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    compare("R12", 14'h0);

    // R12: operation resumes after reset
    drive(1'b1, 9'h1A5, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    compare("R12", {3'b110, 9'h1A5, 2'b10});
    drive(1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    compare("R5", {3'b100, 9'h1A5, 2'b10});

    finish_run();
  end

endmodule